// File: doc/BRIEF.md
# Plug-and-Play Card Initiation and Isolation

This block is the card-side front end of an ISA-style plug-and-play configuration scheme. A freshly reset card ignores every configuration access until the host writes a fixed 32-byte pseudo-random key, one byte at a time, to the shared address port. The card tracks the key with an 8-bit feedback shift register. Once the full key has been matched, the card is unlocked and takes commands as register-index/value pairs: a byte to the address port selects a register, and a byte to the write-data port writes it.

Unlocked, the host can program the read-data port address and assign a card number. It can also wake the card into serial isolation. During isolation the card sends its 72-bit identifier, least significant bit first, as pairs of reads from the read-data port. A control write sends the card back to waiting for the key.

The identifier is a parameter. Read data is combinational from the current state. The host samples it before it pulses the read strobe.

Top module: `pnp_isolation`

## Requirements
- R1: After reset the card is locked (`unlocked`=0), not isolating, `rd_port_addr`=0x00, register index 0x00 and card number 0x00. `rdata` is 0xFF whenever no readable source is selected.
- R2: The key is 32 bytes. It starts at 0x6A, and each next byte is `{b[0]^b[1], b[7:1]}` of the previous byte b. `unlocked` rises in the cycle after the 32nd matching address-port write and not earlier.
- R3: A locked address-port write that does not match the expected byte restarts matching. If that byte equals 0x6A it counts as the first key byte, so the full key may follow at once.
- R4: While locked, write-data port writes change no register.
- R5: Once unlocked, an address-port write sets the register index, and a write-data write stores into the indexed register. Index 0x00 holds `rd_port_addr`.
- R6: Writing index 0x06 sets the card number, and with index 0x06 selected `rdata` returns it.
- R7: Writing 0x00 to index 0x03 starts isolation at identifier bit 0, first read. A nonzero value is ignored.
- R8: With index 0x01 selected during isolation, identifier bit n = CARD_ID[n] (byte k, bit j is n=8k+j). The first read shows 0x55 for a one and 0x00 for a zero. The second read shows 0xAA for a one and 0x00 for a zero. Each strobe advances one read, and isolation ends after the 144th read.
- R9: Writing a value with bit 1 set to index 0x02 relocks the card, stops isolation and clears the index. The full key is then needed again.
- R10: When an address-port write and a read strobe fall in the same cycle, the read is taken under the old register index. The new index applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr | input | 1 | Write strobe for the address port |
| data_wr | input | 1 | Write strobe for the write-data port |
| wdata | input | 8 | Byte written by either strobe |
| rd_strobe | input | 1 | Read strobe of the read-data port |
| rdata | output | 8 | Read-data port value |
| unlocked | output | 1 | Key matched, configuration commands accepted |
| isolating | output | 1 | Serial isolation in progress |
| rd_port_addr | output | 8 | Programmed read-data port address |

## Verification
An address-port write that changes the register index can land in the same cycle as a read strobe during isolation. The bench provokes this from both sides. In one case it leaves the isolation register while reading, and the read must still advance the bit stream. In the other it enters the isolation register while reading, and the read must not advance anything. It judges the outcome from the next read value and its position in the half-bit sequence.

// File: rtl/pnp_isolation.sv
module pnp_isolation #(
  parameter logic [71:0] CARD_ID  = 72'hA5_3C_00_FF_81_7E_12_34_C9,
  parameter int          KEY_LEN  = 32,
  parameter logic [7:0]  KEY_SEED = 8'h6A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_wr,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic       rd_strobe,
  output logic [7:0] rdata,
  output logic       unlocked,
  output logic       isolating,
  output logic [7:0] rd_port_addr
);
  localparam int ID_BITS = 72;
  localparam int PW = $clog2(ID_BITS);
  localparam int KW = $clog2(KEY_LEN + 1);
  localparam logic [PW-1:0] LAST_BIT = PW'(ID_BITS - 1);
  localparam logic [KW-1:0] LAST_KEY = KW'(KEY_LEN - 1);
  localparam logic [7:0] IDX_RDPORT = 8'h00;
  localparam logic [7:0] IDX_ISO    = 8'h01;
  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_WAKE   = 8'h03;
  localparam logic [7:0] IDX_CARD   = 8'h06;

  function automatic logic [7:0] key_step(input logic [7:0] b);
    return {b[0] ^ b[1], b[7:1]};
  endfunction

  logic [7:0]    key_exp;
  logic [KW-1:0] key_cnt;
  logic [7:0]    reg_idx;
  logic [7:0]    card_num;
  logic [PW-1:0] bit_ptr;
  logic          half;

  wire iso_sel = isolating && (reg_idx == IDX_ISO);
  wire iso_rd  = rd_strobe && iso_sel;
  wire cur_bit = CARD_ID[bit_ptr];

  always_comb begin
    if (iso_sel)
      rdata = cur_bit ? (half ? 8'hAA : 8'h55) : 8'h00;
    else if (reg_idx == IDX_CARD)
      rdata = card_num;
    else
      rdata = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked     <= 1'b0;
      isolating    <= 1'b0;
      key_exp      <= KEY_SEED;
      key_cnt      <= '0;
      reg_idx      <= '0;
      rd_port_addr <= '0;
      card_num     <= '0;
      bit_ptr      <= '0;
      half         <= 1'b0;
    end else begin
      if (addr_wr) begin
        if (!unlocked) begin
          if (wdata == key_exp) begin
            if (key_cnt == LAST_KEY) begin
              unlocked <= 1'b1;
              key_cnt  <= '0;
              key_exp  <= KEY_SEED;
            end else begin
              key_cnt <= key_cnt + 1'b1;
              key_exp <= key_step(key_exp);
            end
          end else if (wdata == KEY_SEED) begin
            key_cnt <= KW'(1);
            key_exp <= key_step(KEY_SEED);
          end else begin
            key_cnt <= '0;
            key_exp <= KEY_SEED;
          end
        end else begin
          reg_idx <= wdata;
        end
      end

      if (iso_rd) begin
        half <= !half;
        if (half) begin
          if (bit_ptr == LAST_BIT) isolating <= 1'b0;
          else bit_ptr <= bit_ptr + 1'b1;
        end
      end

      if (data_wr && unlocked) begin
        case (reg_idx)
          IDX_RDPORT: rd_port_addr <= wdata;
          IDX_CARD:   card_num <= wdata;
          IDX_WAKE:
            if (wdata == 8'h00) begin
              isolating <= 1'b1;
              bit_ptr   <= '0;
              half      <= 1'b0;
            end
          IDX_CTRL:
            if (wdata[1]) begin
              unlocked  <= 1'b0;
              isolating <= 1'b0;
              reg_idx   <= '0;
              half      <= 1'b0;
            end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pnp_isolation_chk.sv
module pnp_isolation_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr_wr,
  input logic       data_wr,
  input logic [7:0] wdata,
  input logic       rd_strobe,
  input logic [7:0] rdata,
  input logic       unlocked,
  input logic       isolating,
  input logic [7:0] rd_port_addr,
  input logic [7:0] reg_idx
);
  a_r2_unlock_on_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(addr_wr));

  a_r4_locked_rdport_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> $stable(rd_port_addr));

  a_r7_wake_needs_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(isolating) |-> $past(data_wr && wdata == 8'h00 && unlocked));

  a_r8_iso_read_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (isolating && reg_idx == 8'h01) |-> (rdata == 8'h00 || rdata == 8'h55 || rdata == 8'hAA));

  a_r8_iso_ends_on_access: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(isolating) |-> $past(rd_strobe || data_wr));

  a_r9_no_iso_while_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !isolating);
endmodule

bind pnp_isolation pnp_isolation_chk chk_i (
  .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr), .wdata(wdata),
  .rd_strobe(rd_strobe), .rdata(rdata), .unlocked(unlocked), .isolating(isolating),
  .rd_port_addr(rd_port_addr), .reg_idx(reg_idx)
);

// File: tb/pnp_isolation_tb.sv
module pnp_isolation_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [71:0] ID = 72'hA5_3C_00_FF_81_7E_12_34_C9;

  logic clk = 0, rst_n = 0, addr_wr = 0, data_wr = 0, rd_strobe = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, rd_port_addr;
  logic unlocked, isolating;
  int checks = 0, errors = 0;
  bit done = 0;

  pnp_isolation #(.CARD_ID(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr), .wdata(wdata),
    .rd_strobe(rd_strobe), .rdata(rdata), .unlocked(unlocked), .isolating(isolating),
    .rd_port_addr(rd_port_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] key_byte(input int i);
    logic [7:0] b = 8'h6A;
    for (int k = 0; k < i; k++) b = {b[0] ^ b[1], b[7:1]};
    return b;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic a, input logic d, input logic r, input logic [7:0] v);
    @(negedge clk);
    addr_wr = a; data_wr = d; rd_strobe = r; wdata = v;
    @(negedge clk);
    addr_wr = 0; data_wr = 0; rd_strobe = 0;
  endtask

  task automatic wr_addr(input logic [7:0] v); cycle(1, 0, 0, v); endtask
  task automatic wr_data(input logic [7:0] v); cycle(0, 1, 0, v); endtask
  task automatic rd_pulse(); cycle(0, 0, 1, 8'h00); endtask

  task automatic send_key(input int first, input int cnt);
    for (int i = first; i < first + cnt; i++) wr_addr(key_byte(i));
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset_state();
    apply_reset();
    check("R1 unlocked", {7'd0, unlocked}, 8'h00);
    check("R1 isolating", {7'd0, isolating}, 8'h00);
    check("R1 rd_port_addr", rd_port_addr, 8'h00);
    check("R1 rdata idle", rdata, 8'hFF);
  endtask

  task automatic t_locked_ignores_data();
    wr_data(8'h33);
    check("R4 locked data write", rd_port_addr, 8'h00);
  endtask

  task automatic t_key_unlock();
    wr_addr(8'h00); wr_addr(8'h00);
    send_key(0, 31);
    check("R2 not after 31", {7'd0, unlocked}, 8'h00);
    send_key(31, 1);
    check("R2 unlocked after 32", {7'd0, unlocked}, 8'h01);
  endtask

  task automatic t_key_break();
    apply_reset();
    send_key(0, 10); wr_addr(8'h00); send_key(10, 22);
    check("R3 broken key stays locked", {7'd0, unlocked}, 8'h00);
    apply_reset();
    send_key(0, 5); send_key(0, 32);
    check("R3 seed byte restarts key", {7'd0, unlocked}, 8'h01);
  endtask

  task automatic t_registers();
    wr_addr(8'h00); wr_data(8'h80);
    check("R5 rd_port_addr", rd_port_addr, 8'h80);
    wr_addr(8'h06); wr_data(8'h02);
    check("R6 card number read", rdata, 8'h02);
    wr_addr(8'h03); wr_data(8'h05);
    check("R7 nonzero wake ignored", {7'd0, isolating}, 8'h00);
  endtask

  task automatic t_isolation();
    wr_addr(8'h03); wr_data(8'h00);
    check("R7 wake starts isolation", {7'd0, isolating}, 8'h01);
    wr_addr(8'h01);
    for (int n = 0; n < 72; n++) begin
      check("R8 first read", rdata, ID[n] ? 8'h55 : 8'h00);
      rd_pulse();
      check("R8 second read", rdata, ID[n] ? 8'hAA : 8'h00);
      rd_pulse();
    end
    check("R8 isolation ends", {7'd0, isolating}, 8'h00);
    check("R8 rdata after end", rdata, 8'hFF);
  endtask

  task automatic t_collision();
    wr_addr(8'h03); wr_data(8'h00); wr_addr(8'h01);
    check("R10 bit0 first", rdata, 8'h55);
    cycle(1, 0, 1, 8'h06);
    check("R10 new index applies", rdata, 8'h02);
    cycle(1, 0, 1, 8'h01);
    check("R10 read under old index not advanced", rdata, 8'hAA);
    rd_pulse();
    check("R10 next bit", rdata, ID[1] ? 8'h55 : 8'h00);
  endtask

  task automatic t_relock();
    wr_addr(8'h02); wr_data(8'h02);
    check("R9 relocked", {7'd0, unlocked}, 8'h00);
    check("R9 isolation stopped", {7'd0, isolating}, 8'h00);
    wr_data(8'h44);
    check("R9 data ignored after relock", rd_port_addr, 8'h80);
    send_key(0, 32);
    check("R9 key accepted again", {7'd0, unlocked}, 8'h01);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_locked_ignores_data();
    t_key_unlock();
    t_key_break();
    t_registers();
    t_isolation();
    t_collision();
    t_relock();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule